// File: doc/BRIEF.md
# UART Register File and Interrupt Logic

This block is the software-visible face of a serial port. It decodes a 32-bit, word-aligned register bus into ten registers: a fixed revision word, control, status, scratch, baud clock, an interrupt-enable register with separate set and clear aliases, a receive buffer and a transmit holding register. The serial shift engines and the baud divisor sit outside. This block hands them the control and clock words and exchanges characters with them through strobes.

Receive characters arrive as one-cycle valid pulses with their error flags. They land in a single holding stage that software drains by reading the receive buffer. Transmit characters written by software wait in a one-entry holding stage until the transmit engine takes them with a valid/ready handshake. That handshake is gated by the clear-to-send input when automatic flow control is on. The block drives three interrupt lines: receive, transmit and line/modem status.

Top module: `uart_regfile`

## Requirements
- R1: After reset, control, scratch, clock and interrupt-enable read 0. Status reads 0x20 while the clear-to-send pin is high. The revision word at 0x00 reads the ID_VALUE parameter, and writes to it are ignored.
- R2: A read returns its data on busRdData one cycle after busRdEn. A write is visible to a read issued in the next cycle. Control (0x04), scratch (0x0C) and clock (0x10) hold all 32 written bits.
- R3: Interrupt enable (0x14) holds bits [6:0], and bits above 6 read as 0. Writing 0x14 replaces the register. Ones written to 0x18 set the matching enable bits, and ones written to 0x1C clear them. Every other bit keeps its value.
- R4: A received character sets status bit 0 (data ready). Reading 0x20 returns the character in bits [7:0] and clears bit 0 when no new character arrives in that cycle.
- R5: A character that arrives while bit 0 is set and no read of 0x20 is under way is discarded, and sticky status bit 1 (overrun) is set.
- R6: The parity, framing and break flags of a stored character set sticky status bits 2, 3 and 4. Each sticky bit clears only when a 1 is written to it at status offset 0x08, and writing all ones clears every sticky bit. Writing 1 to bit 0 has no effect.
- R7: Status bit 16 reads 1 while the active-low ctsN pin is low, after a two-flop synchronizer. Every change of the synchronized level sets sticky bit 12, which is cleared by writing 1 to it.
- R8: A write to 0x24 while the holding stage is empty loads bits [7:0], raises txValid and clears status bit 5 (holding empty). A write while it is full is ignored. A cycle with txValid and txReady both high empties the stage.
- R9: While control bit 28 is set and the synchronized ctsN is high, txValid stays low and the character is kept.
- R10: rtsN is low when control bit 25 is set, or when control bit 27 is set and status bit 0 is clear. Otherwise rtsN is high.
- R11: rxIrq equals status bit 0 AND enable bit 0. txIrq equals status bit 5 AND enable bit 1. statIrq equals (any of status bits 1 to 4 AND enable bit 2) OR (status bit 12 AND enable bit 3).
- R12: When a character arrives in the same cycle that 0x20 is read, the read returns the old character, the new one is stored, bit 0 stays set and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, one cycle after busRdEn |
| rxValid | input | 1 | One-cycle pulse: receive engine has a character |
| rxData | input | CHAR_W | Received character |
| rxParErr | input | 1 | Parity error on this character |
| rxFrmErr | input | 1 | Framing error on this character |
| rxBrk | input | 1 | Break seen on this character |
| txValid | output | 1 | Holding stage offers a character |
| txReady | input | 1 | Transmit engine accepts the character |
| txData | output | CHAR_W | Character offered to the transmit engine |
| ctsN | input | 1 | Clear-to-send pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| cfgCtl | output | DATA_W | Control word for the serial engines |
| cfgClk | output | DATA_W | Clock word for the baud divisor |
| rxIrq | output | 1 | Receive interrupt |
| txIrq | output | 1 | Transmit interrupt |
| statIrq | output | 1 | Line and modem status interrupt |

## Verification
Register and flag updates take effect at the clock edge of the bus or strobe cycle. The bench drives on the falling edge and samples on the next falling edge, so interrupts, txValid and rtsN are checked half a cycle after the updating edge. Read data is registered, so every read task samples busRdData one full cycle after raising busRdEn. The clear-to-send path takes two edges to reach status bit 16 and the transmit gate, and a third edge to set the change flag. The bench waits three falling edges after moving ctsN before it checks either result. In the automatic flow test it also checks that txValid is still low one cycle after the pin falls.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

  // Word offsets on the register bus
  localparam logic [5:0] OFS_ID     = 6'h00;
  localparam logic [5:0] OFS_CTL    = 6'h04;
  localparam logic [5:0] OFS_STAT   = 6'h08;
  localparam logic [5:0] OFS_SCR    = 6'h0C;
  localparam logic [5:0] OFS_CLK    = 6'h10;
  localparam logic [5:0] OFS_IER    = 6'h14;
  localparam logic [5:0] OFS_IERSET = 6'h18;
  localparam logic [5:0] OFS_IERCLR = 6'h1C;
  localparam logic [5:0] OFS_RBR    = 6'h20;
  localparam logic [5:0] OFS_THR    = 6'h24;

  // Status bit positions
  localparam int ST_DR     = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_PAR    = 2;
  localparam int ST_FRM    = 3;
  localparam int ST_BRK    = 4;
  localparam int ST_HEMPTY = 5;
  localparam int ST_CTSCHG = 12;
  localparam int ST_CTS    = 16;

  // Control bit positions
  localparam int CT_MRTS = 25;
  localparam int CT_ARTS = 27;
  localparam int CT_ACTS = 28;

  // Interrupt enable bit positions
  localparam int IE_RX = 0;
  localparam int IE_TX = 1;
  localparam int IE_LS = 2;
  localparam int IE_MS = 3;

  typedef enum logic [2:0] {
    SEL_ID, SEL_CTL, SEL_STAT, SEL_SCR, SEL_CLK, SEL_IER, SEL_RBR, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic wrCtl;
    logic wrScr;
    logic wrClk;
    logic wrIer;
    logic setIer;
    logic clrIer;
    logic wrStat;
    logic wrThr;
    logic rdRbr;
  } regStrobe_t;

endpackage

// File: rtl/uart_regfile_ctrl.sv
module uart_regfile_ctrl
  import uart_regfile_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IER_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [IER_W-1:0]  ierQ,
  input  logic              dataReady,
  input  logic              holdEmpty,
  input  logic              errAny,
  input  logic              ctsChg,
  output regStrobe_t        strb,
  output rdSel_e            rdSel,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              statIrq
);

  always_comb begin
    strb = '0;
    if (busWrEn) begin
      case (busAddr)
        ADDR_W'(OFS_CTL):    strb.wrCtl  = 1'b1;
        ADDR_W'(OFS_STAT):   strb.wrStat = 1'b1;
        ADDR_W'(OFS_SCR):    strb.wrScr  = 1'b1;
        ADDR_W'(OFS_CLK):    strb.wrClk  = 1'b1;
        ADDR_W'(OFS_IER):    strb.wrIer  = 1'b1;
        ADDR_W'(OFS_IERSET): strb.setIer = 1'b1;
        ADDR_W'(OFS_IERCLR): strb.clrIer = 1'b1;
        ADDR_W'(OFS_THR):    strb.wrThr  = 1'b1;
        default: ;
      endcase
    end
    strb.rdRbr = busRdEn && (busAddr == ADDR_W'(OFS_RBR));
  end

  always_comb begin
    rdSel = SEL_NONE;
    case (busAddr)
      ADDR_W'(OFS_ID):   rdSel = SEL_ID;
      ADDR_W'(OFS_CTL):  rdSel = SEL_CTL;
      ADDR_W'(OFS_STAT): rdSel = SEL_STAT;
      ADDR_W'(OFS_SCR):  rdSel = SEL_SCR;
      ADDR_W'(OFS_CLK):  rdSel = SEL_CLK;
      ADDR_W'(OFS_IER):  rdSel = SEL_IER;
      ADDR_W'(OFS_RBR):  rdSel = SEL_RBR;
      default:           rdSel = SEL_NONE;
    endcase
  end

  // Interrupt combination (R11)
  assign rxIrq   = dataReady & ierQ[IE_RX];
  assign txIrq   = holdEmpty & ierQ[IE_TX];
  assign statIrq = (errAny & ierQ[IE_LS]) | (ctsChg & ierQ[IE_MS]);

  // R2: at most one register write per bus cycle
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtl, strb.wrScr, strb.wrClk, strb.wrIer, strb.setIer,
              strb.clrIer, strb.wrStat, strb.wrThr}));

  // R2: an unmapped address raises no write strobe
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[1:0] != 2'b00) |->
      !(strb.wrCtl || strb.wrScr || strb.wrThr || strb.wrStat));

endmodule

// File: rtl/uart_regfile_data.sv
module uart_regfile_data
  import uart_regfile_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              CHAR_W   = 8,
  parameter int              IER_W    = 7,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0003_0102
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  rdSel_e            rdSel,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              rxBrk,
  output logic              txValid,
  input  logic              txReady,
  output logic [CHAR_W-1:0] txData,
  input  logic              ctsN,
  output logic              rtsN,
  output logic [DATA_W-1:0] cfgCtl,
  output logic [DATA_W-1:0] cfgClk,
  output logic [IER_W-1:0]  ierQ,
  output logic              dataReady,
  output logic              holdEmpty,
  output logic              errAny,
  output logic              ctsChg
);

  localparam int IER_PAD  = DATA_W - IER_W;
  localparam int CHAR_PAD = DATA_W - CHAR_W;

  logic [DATA_W-1:0] ctlQ, scrQ, clkQ, rdDataQ, statWord;
  logic [CHAR_W-1:0] rxBuf, holdData;
  logic              holdFull;
  logic              ovrFlag, parFlag, frmFlag, brkFlag;
  logic              ctsMeta, ctsSync, ctsPrev;
  logic              acceptRx, overrunNow, ctsEdge;
  logic [DATA_W-1:0] w1c;

  // Plain configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
      scrQ <= '0;
      clkQ <= '0;
    end else begin
      if (strb.wrCtl) ctlQ <= busWrData;
      if (strb.wrScr) scrQ <= busWrData;
      if (strb.wrClk) clkQ <= busWrData;
    end
  end

  // Interrupt enable with set/clear aliases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ierQ <= '0;
    else if (strb.wrIer)  ierQ <= busWrData[IER_W-1:0];
    else if (strb.setIer) ierQ <= ierQ | busWrData[IER_W-1:0];
    else if (strb.clrIer) ierQ <= ierQ & ~busWrData[IER_W-1:0];
  end

  // Receive holding stage
  assign acceptRx   = rxValid && (!dataReady || strb.rdRbr);
  assign overrunNow = rxValid && dataReady && !strb.rdRbr;
  assign w1c        = strb.wrStat ? busWrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf     <= '0;
      dataReady <= 1'b0;
    end else if (acceptRx) begin
      rxBuf     <= rxData;
      dataReady <= 1'b1;
    end else if (strb.rdRbr) begin
      dataReady <= 1'b0;
    end
  end

  // Sticky error flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
      parFlag <= 1'b0;
      frmFlag <= 1'b0;
      brkFlag <= 1'b0;
      ctsChg  <= 1'b0;
    end else begin
      ovrFlag <= overrunNow             | (ovrFlag & ~w1c[ST_OVR]);
      parFlag <= (acceptRx & rxParErr)  | (parFlag & ~w1c[ST_PAR]);
      frmFlag <= (acceptRx & rxFrmErr)  | (frmFlag & ~w1c[ST_FRM]);
      brkFlag <= (acceptRx & rxBrk)     | (brkFlag & ~w1c[ST_BRK]);
      ctsChg  <= ctsEdge                | (ctsChg  & ~w1c[ST_CTSCHG]);
    end
  end

  assign errAny = ovrFlag | parFlag | frmFlag | brkFlag;

  // Clear-to-send synchronizer, idle level is high (deasserted)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b1;
      ctsSync <= 1'b1;
      ctsPrev <= 1'b1;
    end else begin
      ctsMeta <= ctsN;
      ctsSync <= ctsMeta;
      ctsPrev <= ctsSync;
    end
  end

  assign ctsEdge = ctsSync ^ ctsPrev;

  // Transmit holding stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else if (strb.wrThr && !holdFull) begin
      holdFull <= 1'b1;
      holdData <= busWrData[CHAR_W-1:0];
    end else if (txValid && txReady) begin
      holdFull <= 1'b0;
    end
  end

  assign holdEmpty = ~holdFull;
  assign txValid   = holdFull & ~(ctlQ[CT_ACTS] & ctsSync);
  assign txData    = holdData;
  assign rtsN      = ~(ctlQ[CT_MRTS] | (ctlQ[CT_ARTS] & ~dataReady));
  assign cfgCtl    = ctlQ;
  assign cfgClk    = clkQ;

  always_comb begin
    statWord             = '0;
    statWord[ST_DR]      = dataReady;
    statWord[ST_OVR]     = ovrFlag;
    statWord[ST_PAR]     = parFlag;
    statWord[ST_FRM]     = frmFlag;
    statWord[ST_BRK]     = brkFlag;
    statWord[ST_HEMPTY]  = holdEmpty;
    statWord[ST_CTSCHG]  = ctsChg;
    statWord[ST_CTS]     = ~ctsSync;
  end

  // Registered read return
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdDataQ <= '0;
    else if (busRdEn) begin
      case (rdSel)
        SEL_ID:   rdDataQ <= ID_VALUE;
        SEL_CTL:  rdDataQ <= ctlQ;
        SEL_STAT: rdDataQ <= statWord;
        SEL_SCR:  rdDataQ <= scrQ;
        SEL_CLK:  rdDataQ <= clkQ;
        SEL_IER:  rdDataQ <= {{IER_PAD{1'b0}}, ierQ};
        SEL_RBR:  rdDataQ <= {{CHAR_PAD{1'b0}}, rxBuf};
        default:  rdDataQ <= '0;
      endcase
    end
  end

  assign busRdData = rdDataQ;

  assert_ier_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setIer |=> ((ierQ & $past(busWrData[IER_W-1:0])) == $past(busWrData[IER_W-1:0])));

  assert_ier_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrIer |=> ((ierQ & $past(busWrData[IER_W-1:0])) == '0));

  assert_pop_clears_dr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdRbr && !rxValid) |=> !dataReady);

  assert_overrun_keeps_char_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && dataReady && !strb.rdRbr) |=> (ovrFlag && $stable(rxBuf)));

  assert_cts_change_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctsSync != ctsPrev) |=> ctsChg);

  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !(txValid && txReady)) |=> (holdFull && $stable(holdData)));

  assert_simul_pop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && strb.rdRbr) |=> (dataReady && !$rose(ovrFlag)));

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int                ADDR_W   = 6,
  parameter int                DATA_W   = 32,
  parameter int                CHAR_W   = 8,
  parameter int                IER_W    = 7,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0003_0102
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              rxBrk,
  output logic              txValid,
  input  logic              txReady,
  output logic [CHAR_W-1:0] txData,
  input  logic              ctsN,
  output logic              rtsN,
  output logic [DATA_W-1:0] cfgCtl,
  output logic [DATA_W-1:0] cfgClk,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              statIrq
);

  regStrobe_t       strb;
  rdSel_e           rdSel;
  logic [IER_W-1:0] ierQ;
  logic             dataReady, holdEmpty, errAny, ctsChg;

  uart_regfile_ctrl #(.ADDR_W(ADDR_W), .IER_W(IER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .ierQ(ierQ), .dataReady(dataReady),
    .holdEmpty(holdEmpty), .errAny(errAny), .ctsChg(ctsChg),
    .strb(strb), .rdSel(rdSel), .rxIrq(rxIrq), .txIrq(txIrq),
    .statIrq(statIrq)
  );

  uart_regfile_data #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W), .IER_W(IER_W), .ID_VALUE(ID_VALUE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .rxValid(rxValid),
    .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .rxBrk(rxBrk), .txValid(txValid), .txReady(txReady), .txData(txData),
    .ctsN(ctsN), .rtsN(rtsN), .cfgCtl(cfgCtl), .cfgClk(cfgClk),
    .ierQ(ierQ), .dataReady(dataReady), .holdEmpty(holdEmpty),
    .errAny(errAny), .ctsChg(ctsChg)
  );

endmodule

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;

  localparam logic [31:0] ID_EXP = 32'h0003_0102;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxParErr = 1'b0, rxFrmErr = 1'b0, rxBrk = 1'b0;
  logic        txValid, txReady = 1'b0;
  logic [7:0]  txData;
  logic        ctsN = 1'b1, rtsN;
  logic [31:0] cfgCtl, cfgClk;
  logic        rxIrq, txIrq, statIrq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  uart_regfile #(.ID_VALUE(ID_EXP)) u_uart_regfile (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBrk(rxBrk), .txValid(txValid),
    .txReady(txReady), .txData(txData), .ctsN(ctsN), .rtsN(rtsN),
    .cfgCtl(cfgCtl), .cfgClk(cfgClk), .rxIrq(rxIrq), .txIrq(txIrq),
    .statIrq(statIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic rxChar(input logic [7:0] c, input logic p, input logic f, input logic b);
    @(negedge clk);
    rxValid = 1'b1; rxData = c; rxParErr = p; rxFrmErr = f; rxBrk = b;
    @(negedge clk);
    rxValid = 1'b0; rxParErr = 1'b0; rxFrmErr = 1'b0; rxBrk = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(6'h00, v); check("R1 id", v, ID_EXP);
    busRead(6'h04, v); check("R1 ctl", v, 0);
    busRead(6'h08, v); check("R1 stat", v, 32'h20);
    busRead(6'h0C, v); check("R1 scr", v, 0);
    busRead(6'h14, v); check("R1 ier", v, 0);
    check("R1 irqs", {rxIrq, txIrq, statIrq, txValid, rtsN}, 5'b00001);
    busWrite(6'h00, 32'hDEAD_BEEF);
    busRead(6'h00, v); check("R1 id write ignored", v, ID_EXP);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    busWrite(6'h0C, 32'hA5A5_5A5A);
    busRead(6'h0C, v); check("R2 scratch", v, 32'hA5A5_5A5A);
    busWrite(6'h10, 32'h8000_0123);
    busRead(6'h10, v); check("R2 clock", v, 32'h8000_0123);
    check("R2 cfgClk", cfgClk, 32'h8000_0123);
    busWrite(6'h04, 32'h0000_0300);
    busRead(6'h04, v); check("R2 control", v, 32'h0000_0300);
    busWrite(6'h04, 32'h0);
  endtask

  task automatic testIer();
    logic [31:0] v;
    busWrite(6'h14, 32'h05);
    busWrite(6'h18, 32'h0A);
    busRead(6'h14, v); check("R3 set alias", v, 32'h0F);
    busWrite(6'h1C, 32'h03);
    busRead(6'h14, v); check("R3 clear alias", v, 32'h0C);
    busWrite(6'h14, 32'hFFFF_FFFF);
    busRead(6'h14, v); check("R3 direct upper zero", v, 32'h7F);
    busWrite(6'h14, 32'h0);
  endtask

  task automatic testRx();
    logic [31:0] v;
    busWrite(6'h14, 32'h01);
    rxChar(8'h41, 0, 0, 0);
    check("R11 rxIrq on", rxIrq, 1);
    busRead(6'h08, v); check("R4 dr set", v & 32'h1F, 32'h01);
    busRead(6'h20, v); check("R4 char", v, 32'h41);
    busRead(6'h08, v); check("R4 dr clear", v & 32'h1F, 32'h00);
    check("R11 rxIrq off", rxIrq, 0);
    busWrite(6'h14, 32'h0);
  endtask

  task automatic testOverrun();
    logic [31:0] v;
    rxChar(8'h11, 0, 0, 0);
    rxChar(8'h22, 0, 0, 0);
    busRead(6'h08, v); check("R5 overrun", v & 32'h1F, 32'h03);
    busRead(6'h20, v); check("R5 first kept", v, 32'h11);
    busRead(6'h08, v); check("R5 sticky", v & 32'h1F, 32'h02);
    busWrite(6'h08, 32'hFFFF_FFFF);
    busRead(6'h08, v); check("R6 all ones clear", v & 32'h1F, 32'h00);
  endtask

  task automatic testErrors();
    logic [31:0] v;
    busWrite(6'h14, 32'h04);
    rxChar(8'h10, 1, 0, 0);
    busRead(6'h08, v); check("R6 parity", v & 32'h1F, 32'h05);
    check("R11 statIrq err", statIrq, 1);
    busRead(6'h20, v);
    busWrite(6'h08, 32'h04);
    busRead(6'h08, v); check("R6 w1c parity", v & 32'h1F, 32'h00);
    check("R11 statIrq off", statIrq, 0);
    rxChar(8'h20, 0, 1, 1);
    busRead(6'h08, v); check("R6 frame+break", v & 32'h1F, 32'h19);
    busWrite(6'h08, 32'h01);
    busRead(6'h08, v); check("R6 dr write no effect", v & 32'h1F, 32'h19);
    busRead(6'h20, v);
    busWrite(6'h08, 32'hFFFF_FFFF);
    busRead(6'h08, v); check("R6 cleared", v & 32'h1F, 32'h00);
    busWrite(6'h14, 32'h0);
  endtask

  task automatic testCts();
    logic [31:0] v;
    busWrite(6'h14, 32'h08);
    @(negedge clk); ctsN = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 statIrq modem", statIrq, 1);
    busRead(6'h08, v); check("R7 cts live+chg", v & 32'h0001_1000, 32'h0001_1000);
    busWrite(6'h08, 32'h1000);
    busRead(6'h08, v); check("R7 chg w1c", v & 32'h0001_1000, 32'h0001_0000);
    @(negedge clk); ctsN = 1'b1;
    repeat (3) @(negedge clk);
    busRead(6'h08, v); check("R7 release", v & 32'h0001_1000, 32'h0000_1000);
    busWrite(6'h08, 32'h1000);
    busWrite(6'h14, 32'h0);
  endtask

  task automatic testTx();
    logic [31:0] v;
    busWrite(6'h14, 32'h02);
    check("R11 txIrq empty", txIrq, 1);
    busWrite(6'h24, 32'h5A);
    check("R8 txValid", {txValid, txData}, {1'b1, 8'h5A});
    check("R11 txIrq full", txIrq, 0);
    busRead(6'h08, v); check("R8 hold empty clear", v & 32'h20, 32'h0);
    busWrite(6'h24, 32'h33);
    check("R8 write while full ignored", txData, 8'h5A);
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    check("R8 drained", {txValid, txIrq}, 2'b01);
    busWrite(6'h14, 32'h0);
  endtask

  task automatic testAutoCts();
    busWrite(6'h04, 32'h1000_0000);
    busWrite(6'h24, 32'h77);
    check("R9 blocked", txValid, 0);
    @(negedge clk); ctsN = 1'b0;
    @(negedge clk);
    check("R9 still blocked in sync", txValid, 0);
    @(negedge clk);
    check("R9 released", {txValid, txData}, {1'b1, 8'h77});
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    ctsN = 1'b1;
    repeat (3) @(negedge clk);
    busWrite(6'h04, 32'h0);
    busWrite(6'h08, 32'hFFFF_FFFF);
  endtask

  task automatic testRts();
    logic [31:0] v;
    busWrite(6'h04, 32'h0200_0000);
    check("R10 manual", rtsN, 0);
    busWrite(6'h04, 32'h0800_0000);
    check("R10 auto empty", rtsN, 0);
    rxChar(8'h55, 0, 0, 0);
    check("R10 auto full", rtsN, 1);
    busRead(6'h20, v);
    check("R10 auto drained", rtsN, 0);
    busWrite(6'h04, 32'h0);
    check("R10 off", rtsN, 1);
  endtask

  task automatic testSimul();
    logic [31:0] v;
    rxChar(8'h31, 0, 0, 0);
    @(negedge clk);
    busAddr = 6'h20; busRdEn = 1'b1; rxValid = 1'b1; rxData = 8'h32;
    @(negedge clk);
    busRdEn = 1'b0; rxValid = 1'b0;
    check("R12 old returned", busRdData, 32'h31);
    busRead(6'h08, v); check("R12 no overrun", v & 32'h1F, 32'h01);
    busRead(6'h20, v); check("R12 new stored", v, 32'h32);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testRegs();
    testIer();
    testRx();
    testOverrun();
    testErrors();
    testCts();
    testTx();
    testAutoCts();
    testRts();
    testSimul();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule